// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a translation miss into a resolved page entry. Each request carries a context number (0 to 15) and a 40-bit virtual address. The walker reads 64-bit entries from memory through a read port that takes one request and returns one response. It reads a directory entry and then a table entry, or only a table entry when the context uses a single flat table. It then reports the fields of the page entry, or a fault.

Every context has its own table base address. Context 0 has its own depth and block-size settings. Contexts 1 to 15 share one depth setting and one block-size setting. A block-size value of n makes each table block hold 512·2^n entries. The table index is therefore VA[20+n:12], and the directory index is every VA bit above it. The walker takes a snapshot of the settings when it accepts a request, so a change to the settings during a walk does not affect that walk.

Top module: `gpu_pt_walker`

## Requirements
- R1: After a synchronous active-low reset the walker is idle. `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: In single-level mode the only read goes to base + VA[39:12]·8.
- R3: In two-level mode the first read goes to base + (VA >> (21+n))·8, where n is the effective block size.
- R4: After a valid directory entry D, the second read goes to {D[39:12], 12'h000} + VA[20+n:12]·8.
- R5: Context 0 uses `cfg0_two_level` and `cfg0_blk_size`. Contexts 1 to 15 use `cfgx_two_level` and `cfgx_blk_size`. Each context reads its own slice of `ctx_base`.
- R6: A directory entry with bit 0 clear ends the walk with `res_fault`=1 and `res_fault_tbl`=0. No table read is issued.
- R7: A table entry with bit 0 clear ends the walk with `res_fault`=1 and `res_fault_tbl`=1.
- R8: A table entry with bit 0 set gives a result with `res_fault`=0. The result fields are page = E[39:12], fragment = E[11:7], write = E[6], read = E[5], snoop = E[2] and system = E[1]. Bits 63:40 and 4:3 are ignored.
- R9: At most one read is outstanding. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. The next read is issued only after the response arrives. Responses that arrive while no read is outstanding are ignored.
- R10: A request is accepted only while idle, when `req_ready` is 1. `res_valid` is a single-cycle pulse, and `req_ready` is 0 during that pulse.
- R11: A block-size value above 18 is treated as 18, so the directory keeps at least one index bit (VA[39]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_ctx | input | 4 | Context number of the request |
| req_va | input | 40 | Virtual address to translate |
| ctx_base | input | 16×40 | Table base byte address for each context |
| cfg0_two_level | input | 1 | Context 0 uses two-level tables |
| cfg0_blk_size | input | 5 | Context 0 block-size value |
| cfgx_two_level | input | 1 | Contexts 1 to 15 use two-level tables |
| cfgx_blk_size | input | 5 | Block-size value shared by contexts 1 to 15 |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_fault_tbl | output | 1 | Fault came from a table entry (0: from a directory entry) |
| res_page | output | 28 | Page address bits 39:12 |
| res_frag | output | 5 | Fragment size code |
| res_write | output | 1 | Write permitted |
| res_read | output | 1 | Read permitted |
| res_snoop | output | 1 | Access snoops the CPU cache |
| res_system | output | 1 | Page lies in system memory |

## Verification
Two events can fall in the same cycle: the result pulse of one walk and a new request that is waiting. The bench provokes this by switching the inputs to a second request from another context and holding `req_valid` high for the whole first walk. It then checks three things. `req_ready` must be low during the first pulse. The first result must carry the first walk's entry. The second walk must start only after that pulse and must read from its own context's base. Reads stalled by a toggling `mem_req_ready` check that requests are held and ordered.

// File: rtl/ptw_pkg.sv
// Package for the page table walker.
// Holds the fixed entry format constants and the walker state type.
// Assumes 64-bit entries whose address field ends at bit 39.
package ptw_pkg;

    localparam int ENTRY_W       = 64;
    localparam int PAGE_SHIFT    = 12;
    localparam int BLK_IDX_MIN   = 9;
    localparam int ENTRY_SHIFT   = 3;

    // Bit positions inside a table entry
    localparam int BIT_VALID     = 0;
    localparam int BIT_SYSTEM    = 1;
    localparam int BIT_SNOOP     = 2;
    localparam int BIT_READ      = 5;
    localparam int BIT_WRITE     = 6;
    localparam int FRAG_LSB      = 7;
    localparam int FRAG_W        = 5;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READ_PDE = 3'd1,
        ST_READ_PTE = 3'd2,
        ST_DONE     = 3'd3,
        ST_FAULT    = 3'd4
    } walk_state_t;

endpackage

// File: rtl/ptw_cfg_sel.sv
// Picks the walk settings for the requesting context.
// Context 0 has private depth and block-size settings; the other contexts
// share one set. The block size is clamped so the directory index keeps at
// least one bit. Assumes NUM_CTX >= 1.
module ptw_cfg_sel #(
    parameter int NUM_CTX = 16,
    parameter int CTX_W   = 4,
    parameter int VA_W    = 40,
    parameter int PA_W    = 40,
    parameter int BS_W    = 5
) (
    input  logic [CTX_W-1:0]              ctx,
    input  logic [NUM_CTX-1:0][PA_W-1:0]  ctx_base,
    input  logic                          cfg0_two_level,
    input  logic [BS_W-1:0]               cfg0_blk_size,
    input  logic                          cfgx_two_level,
    input  logic [BS_W-1:0]               cfgx_blk_size,
    output logic                          sel_two_level,
    output logic [BS_W-1:0]               sel_blk_size,
    output logic [PA_W-1:0]               sel_base
);
    import ptw_pkg::*;

    localparam int MAX_BS = VA_W - PAGE_SHIFT - BLK_IDX_MIN - 1;

    logic [BS_W-1:0] raw_bs;

    generate
        if (NUM_CTX > 1) begin : g_shared
            // Route context 0 to its own settings, every other context to the shared ones
            always_comb begin
                if (ctx == '0) begin
                    sel_two_level = cfg0_two_level;
                    raw_bs        = cfg0_blk_size;
                end else begin
                    sel_two_level = cfgx_two_level;
                    raw_bs        = cfgx_blk_size;
                end
            end
        end else begin : g_single
            logic unused_shared;
            assign unused_shared = ^{cfgx_two_level, cfgx_blk_size};
            // Only context 0 exists
            always_comb begin
                sel_two_level = cfg0_two_level;
                raw_bs        = cfg0_blk_size;
            end
        end
    endgenerate

    // Clamp the block size so the directory index stays non-empty
    always_comb begin
        if (raw_bs > BS_W'(MAX_BS)) sel_blk_size = BS_W'(MAX_BS);
        else                        sel_blk_size = raw_bs;
    end

    // Select the table base of the requesting context
    always_comb begin
        sel_base = ctx_base[ctx];
    end

endmodule

// File: rtl/ptw_addr_gen.sv
// Forms the byte address of the next entry to read.
// Directory reads index with the VA bits above the table index, table reads
// index with VA[PAGE_SHIFT+BLK_IDX_MIN+n-1:PAGE_SHIFT], single-level reads
// index with the whole page number. Assumes n is already clamped.
module ptw_addr_gen #(
    parameter int VA_W = 40,
    parameter int PA_W = 40,
    parameter int BS_W = 5
) (
    input  logic [VA_W-1:0] va,
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] ptb,
    input  logic [BS_W-1:0] blk_size,
    input  logic            two_level,
    input  logic            read_pde,
    output logic [PA_W-1:0] entry_addr
);
    import ptw_pkg::*;

    localparam int IDX_W = VA_W - PAGE_SHIFT;

    logic [IDX_W-1:0] vpn;
    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_mask;
    logic [IDX_W-1:0] tbl_idx;
    logic [PA_W-1:0]  pde_addr;
    logic [PA_W-1:0]  pte_addr;

    // Split the virtual page number into directory and table indices
    always_comb begin
        vpn      = va[VA_W-1:PAGE_SHIFT];
        dir_idx  = vpn >> (BLK_IDX_MIN + int'(blk_size));
        tbl_mask = ~({IDX_W{1'b1}} << (BLK_IDX_MIN + int'(blk_size)));
        tbl_idx  = vpn & tbl_mask;
    end

    // Scale the indices to byte offsets and add the matching base
    always_comb begin
        pde_addr = base + (PA_W'(dir_idx) << ENTRY_SHIFT);
        if (two_level) pte_addr = ptb  + (PA_W'(tbl_idx) << ENTRY_SHIFT);
        else           pte_addr = base + (PA_W'(vpn) << ENTRY_SHIFT);
        entry_addr = read_pde ? pde_addr : pte_addr;
    end

endmodule

// File: rtl/ptw_fsm.sv
// Walk sequencer: accepts a request when idle, snapshots its settings,
// issues one entry read at a time and ends in a success or fault pulse.
// Assumes the memory returns exactly one response per accepted read.
module ptw_fsm #(
    parameter int VA_W = 40,
    parameter int PA_W = 40,
    parameter int BS_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [VA_W-1:0]              req_va,
    input  logic                         sel_two_level,
    input  logic [BS_W-1:0]              sel_blk_size,
    input  logic [PA_W-1:0]              sel_base,
    output logic [VA_W-1:0]              va_q,
    output logic [PA_W-1:0]              base_q,
    output logic [BS_W-1:0]              blk_size_q,
    output logic                         two_level_q,
    output logic [PA_W-1:0]              ptb_q,
    output logic                         read_pde,
    input  logic [PA_W-1:0]              entry_addr,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [PA_W-1:0]              mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [ptw_pkg::ENTRY_W-1:0]  mem_rsp_data,
    output logic                         res_valid,
    output logic                         res_fault,
    output logic                         res_fault_tbl,
    output logic [PA_W-ptw_pkg::PAGE_SHIFT-1:0] res_page,
    output logic [ptw_pkg::FRAG_W-1:0]   res_frag,
    output logic                         res_write,
    output logic                         res_read,
    output logic                         res_snoop,
    output logic                         res_system
);
    import ptw_pkg::*;

    localparam int PAGE_W = PA_W - PAGE_SHIFT;

    walk_state_t       state;
    logic              issued;
    logic              fault_tbl_q;
    logic [PAGE_W-1:0] page_q;
    logic [FRAG_W-1:0] frag_q;
    logic              wr_q, rd_q, snoop_q, sys_q;
    logic              rsp_take;

    logic unused_bits;
    assign unused_bits = ^{mem_rsp_data[ENTRY_W-1:PA_W], mem_rsp_data[4:3]};

    assign rsp_take = issued && mem_rsp_valid;

    // Main walk sequencer with request snapshot and entry capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            issued      <= 1'b0;
            va_q        <= '0;
            base_q      <= '0;
            blk_size_q  <= '0;
            two_level_q <= 1'b0;
            ptb_q       <= '0;
            fault_tbl_q <= 1'b0;
            page_q      <= '0;
            frag_q      <= '0;
            wr_q        <= 1'b0;
            rd_q        <= 1'b0;
            snoop_q     <= 1'b0;
            sys_q       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    issued <= 1'b0;
                    if (req_valid) begin
                        va_q        <= req_va;
                        base_q      <= sel_base;
                        blk_size_q  <= sel_blk_size;
                        two_level_q <= sel_two_level;
                        state       <= sel_two_level ? ST_READ_PDE : ST_READ_PTE;
                    end
                end
                ST_READ_PDE: begin
                    if (!issued && mem_req_ready) issued <= 1'b1;
                    if (rsp_take) begin
                        issued <= 1'b0;
                        if (mem_rsp_data[BIT_VALID]) begin
                            ptb_q <= {mem_rsp_data[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                            state <= ST_READ_PTE;
                        end else begin
                            fault_tbl_q <= 1'b0;
                            state       <= ST_FAULT;
                        end
                    end
                end
                ST_READ_PTE: begin
                    if (!issued && mem_req_ready) issued <= 1'b1;
                    if (rsp_take) begin
                        issued  <= 1'b0;
                        page_q  <= mem_rsp_data[PA_W-1:PAGE_SHIFT];
                        frag_q  <= mem_rsp_data[FRAG_LSB+FRAG_W-1:FRAG_LSB];
                        wr_q    <= mem_rsp_data[BIT_WRITE];
                        rd_q    <= mem_rsp_data[BIT_READ];
                        snoop_q <= mem_rsp_data[BIT_SNOOP];
                        sys_q   <= mem_rsp_data[BIT_SYSTEM];
                        if (mem_rsp_data[BIT_VALID]) begin
                            state <= ST_DONE;
                        end else begin
                            fault_tbl_q <= 1'b1;
                            state       <= ST_FAULT;
                        end
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Handshake and memory port outputs derived from the state
    always_comb begin
        req_ready     = (state == ST_IDLE);
        read_pde      = (state == ST_READ_PDE);
        mem_req_valid = ((state == ST_READ_PDE) || (state == ST_READ_PTE)) && !issued;
        mem_req_addr  = entry_addr;
    end

    // Result outputs, fields only shown on a successful walk
    always_comb begin
        res_valid     = (state == ST_DONE) || (state == ST_FAULT);
        res_fault     = (state == ST_FAULT);
        res_fault_tbl = (state == ST_FAULT) && fault_tbl_q;
        if (state == ST_DONE) begin
            res_page   = page_q;
            res_frag   = frag_q;
            res_write  = wr_q;
            res_read   = rd_q;
            res_snoop  = snoop_q;
            res_system = sys_q;
        end else begin
            res_page   = '0;
            res_frag   = '0;
            res_write  = 1'b0;
            res_read   = 1'b0;
            res_snoop  = 1'b0;
            res_system = 1'b0;
        end
    end

    // A stalled read keeps its request and address
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // No read is requested while a result is presented
    assert_no_read_at_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mem_req_valid);

    // The result lasts exactly one cycle
    assert_result_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // No request is taken during the result pulse
    assert_busy_at_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);

    // An invalid directory entry leads straight to a directory fault
    assert_pde_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (read_pde && rsp_take && !mem_rsp_data[BIT_VALID])
            |=> (res_valid && res_fault && !res_fault_tbl));

    // An invalid table entry leads to a table fault
    assert_pte_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_READ_PTE) && rsp_take && !mem_rsp_data[BIT_VALID])
            |=> (res_valid && res_fault && res_fault_tbl));

endmodule

// File: rtl/gpu_pt_walker.sv
// Top of the page table walker: per-context setting selection, entry
// address formation and the walk sequencer. Assumes a read port that
// returns one response for each accepted request.
module gpu_pt_walker #(
    parameter int NUM_CTX = 16,
    parameter int CTX_W   = $clog2(NUM_CTX),
    parameter int VA_W    = 40,
    parameter int PA_W    = 40,
    parameter int BS_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [CTX_W-1:0]             req_ctx,
    input  logic [VA_W-1:0]              req_va,
    input  logic [NUM_CTX-1:0][PA_W-1:0] ctx_base,
    input  logic                         cfg0_two_level,
    input  logic [BS_W-1:0]              cfg0_blk_size,
    input  logic                         cfgx_two_level,
    input  logic [BS_W-1:0]              cfgx_blk_size,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [PA_W-1:0]              mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [ptw_pkg::ENTRY_W-1:0]  mem_rsp_data,
    output logic                         res_valid,
    output logic                         res_fault,
    output logic                         res_fault_tbl,
    output logic [PA_W-ptw_pkg::PAGE_SHIFT-1:0] res_page,
    output logic [ptw_pkg::FRAG_W-1:0]   res_frag,
    output logic                         res_write,
    output logic                         res_read,
    output logic                         res_snoop,
    output logic                         res_system
);

    logic                 sel_two_level;
    logic [BS_W-1:0]      sel_blk_size;
    logic [PA_W-1:0]      sel_base;
    logic [VA_W-1:0]      va_q;
    logic [PA_W-1:0]      base_q;
    logic [BS_W-1:0]      blk_size_q;
    logic                 two_level_q;
    logic [PA_W-1:0]      ptb_q;
    logic                 read_pde;
    logic [PA_W-1:0]      entry_addr;

    ptw_cfg_sel #(
        .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .VA_W(VA_W), .PA_W(PA_W), .BS_W(BS_W)
    ) cfg_sel_i (
        .ctx            (req_ctx),
        .ctx_base       (ctx_base),
        .cfg0_two_level (cfg0_two_level),
        .cfg0_blk_size  (cfg0_blk_size),
        .cfgx_two_level (cfgx_two_level),
        .cfgx_blk_size  (cfgx_blk_size),
        .sel_two_level  (sel_two_level),
        .sel_blk_size   (sel_blk_size),
        .sel_base       (sel_base)
    );

    ptw_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .BS_W(BS_W)
    ) addr_gen_i (
        .va         (va_q),
        .base       (base_q),
        .ptb        (ptb_q),
        .blk_size   (blk_size_q),
        .two_level  (two_level_q),
        .read_pde   (read_pde),
        .entry_addr (entry_addr)
    );

    ptw_fsm #(
        .VA_W(VA_W), .PA_W(PA_W), .BS_W(BS_W)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .sel_two_level (sel_two_level),
        .sel_blk_size  (sel_blk_size),
        .sel_base      (sel_base),
        .va_q          (va_q),
        .base_q        (base_q),
        .blk_size_q    (blk_size_q),
        .two_level_q   (two_level_q),
        .ptb_q         (ptb_q),
        .read_pde      (read_pde),
        .entry_addr    (entry_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_fault     (res_fault),
        .res_fault_tbl (res_fault_tbl),
        .res_page      (res_page),
        .res_frag      (res_frag),
        .res_write     (res_write),
        .res_read      (res_read),
        .res_snoop     (res_snoop),
        .res_system    (res_system)
    );

endmodule

// File: tb/gpu_pt_walker_tb_top.sv
module gpu_pt_walker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCTX = 16;
    localparam int NVEC = 9;

    typedef struct packed {
        logic [3:0]  ctx;
        logic [39:0] va;
        logic        two0;
        logic [4:0]  bs0;
        logic        twox;
        logic [4:0]  bsx;
        logic        stall;
        logic [63:0] w0;
        logic [63:0] w1;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{4'd0,  40'h12_3456_7000, 1'b0, 5'd0, 1'b1, 5'd0,  1'b0, 64'hFF00_00AB_CDEF_11E3, 64'h0},
        '{4'd5,  40'h7F_FFE0_3000, 1'b0, 5'd0, 1'b1, 5'd0,  1'b0, 64'h0000_0000_5555_5001, 64'h0000_0012_3000_0005},
        '{4'd0,  40'h01_2345_6789, 1'b1, 5'd2, 1'b0, 5'd0,  1'b0, 64'h0000_0000_0AAA_0001, 64'h0000_00F0_0000_0F63},
        '{4'd15, 40'hC0_0020_1000, 1'b0, 5'd0, 1'b1, 5'd25, 1'b0, 64'h0000_0000_0BBB_B001, 64'h0000_0044_4444_4061},
        '{4'd3,  40'h00_1111_2000, 1'b0, 5'd0, 1'b1, 5'd1,  1'b0, 64'h0000_0000_0CCC_C000, 64'h0000_0011_0000_0001},
        '{4'd7,  40'h05_5555_5000, 1'b0, 5'd0, 1'b1, 5'd0,  1'b0, 64'h0000_0000_0DDD_D001, 64'h0000_0077_7777_71E2},
        '{4'd9,  40'h09_9999_9000, 1'b0, 5'd0, 1'b0, 5'd0,  1'b0, 64'h0000_0099_0000_0066, 64'h0},
        '{4'd2,  40'h3A_BCDE_F123, 1'b0, 5'd0, 1'b1, 5'd3,  1'b1, 64'h0000_0000_0EEE_E001, 64'h0000_00AA_AAAA_A0A7},
        '{4'd1,  40'hFF_FFFF_F000, 1'b0, 5'd0, 1'b0, 5'd0,  1'b1, 64'h0000_0012_3456_7027, 64'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [3:0] req_ctx = '0;
    logic [39:0] req_va = '0;
    logic [NCTX-1:0][39:0] ctx_base;
    logic cfg0_two_level = 1'b0, cfgx_two_level = 1'b0;
    logic [4:0] cfg0_blk_size = '0, cfgx_blk_size = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b1;
    logic [39:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic res_valid, res_fault, res_fault_tbl;
    logic [27:0] res_page;
    logic [4:0] res_frag;
    logic res_write, res_read, res_snoop, res_system;

    int checks = 0;
    int errors = 0;
    logic stall_mode = 1'b0;
    logic rec_clr = 1'b0;
    logic [63:0] mem_w0 = '0, mem_w1 = '0;
    logic [39:0] rd_addr [0:3];
    int rd_cnt = 0;
    logic [7:0] cyc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpu_pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_va(req_va), .ctx_base(ctx_base),
        .cfg0_two_level(cfg0_two_level), .cfg0_blk_size(cfg0_blk_size),
        .cfgx_two_level(cfgx_two_level), .cfgx_blk_size(cfgx_blk_size),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
        .res_fault_tbl(res_fault_tbl), .res_page(res_page), .res_frag(res_frag),
        .res_write(res_write), .res_read(res_read), .res_snoop(res_snoop),
        .res_system(res_system)
    );

    function automatic logic [39:0] base_of(input int c);
        return 40'h00_4000_0000 + (40'(c) << 24);
    endfunction

    // Memory model: records read addresses, answers one cycle after acceptance
    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        mem_req_ready <= stall_mode ? (cyc[1] & cyc[0]) : 1'b1;
        if (rec_clr) begin
            rd_cnt <= 0;
            mem_rsp_valid <= 1'b0;
        end else begin
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            if (mem_req_valid && mem_req_ready) begin
                rd_addr[rd_cnt[1:0]] <= mem_req_addr;
                rd_cnt <= rd_cnt + 1;
                mem_rsp_data <= (rd_cnt == 0) ? mem_w0 : mem_w1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_result(output logic got);
        got = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (res_valid) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    // Expected read addresses and result, computed from the requirements
    task automatic expect_walk(input vec_t v, output int e_cnt, output logic [39:0] e_a0,
                               output logic [39:0] e_a1, output logic e_fault,
                               output logic e_tbl, output logic [63:0] e_pte);
        logic two;
        int n;
        logic [63:0] base, va64;
        two  = (v.ctx == 0) ? v.two0 : v.twox;
        n    = (v.ctx == 0) ? int'(v.bs0) : int'(v.bsx);
        if (n > 18) n = 18;
        base = {24'b0, base_of(int'(v.ctx))};
        va64 = {24'b0, v.va};
        e_a1 = '0;
        if (two) begin
            e_a0 = 40'(base + ((va64 >> (21 + n)) << 3));
            if (!v.w0[0]) begin
                e_cnt = 1; e_fault = 1'b1; e_tbl = 1'b0; e_pte = '0;
            end else begin
                e_cnt = 2;
                e_a1 = 40'({24'b0, v.w0[39:12], 12'b0} + (((va64 >> 12) & ((64'd1 << (9 + n)) - 1)) << 3));
                e_pte = v.w1; e_fault = !v.w1[0]; e_tbl = 1'b1;
            end
        end else begin
            e_cnt = 1;
            e_a0 = 40'(base + ((va64 >> 12) << 3));
            e_pte = v.w0; e_fault = !v.w0[0]; e_tbl = 1'b1;
        end
    endtask

    task automatic check_fields(input logic [63:0] e);
        chk(res_page == e[39:12], "R8 page", 64'(res_page), 64'(e[39:12]));
        chk(res_frag == e[11:7], "R8 frag", 64'(res_frag), 64'(e[11:7]));
        chk({res_write, res_read, res_snoop, res_system} == {e[6], e[5], e[2], e[1]},
            "R8 flags", 64'({res_write, res_read, res_snoop, res_system}), 64'({e[6], e[5], e[2], e[1]}));
    endtask

    task automatic run_vec(input vec_t v);
        int e_cnt;
        logic [39:0] e_a0, e_a1;
        logic e_fault, e_tbl, got;
        logic [63:0] e_pte;
        string tag;
        expect_walk(v, e_cnt, e_a0, e_a1, e_fault, e_tbl, e_pte);
        @(negedge clk);
        cfg0_two_level = v.two0; cfg0_blk_size = v.bs0;
        cfgx_two_level = v.twox; cfgx_blk_size = v.bsx;
        mem_w0 = v.w0; mem_w1 = v.w1; stall_mode = v.stall;
        req_ctx = v.ctx; req_va = v.va; req_valid = 1'b1; rec_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rec_clr = 1'b0;
        wait_result(got);
        chk(got, "R10 result arrives", 64'(got), 64'd1);
        if (!got) return;
        if (v.ctx == 0)                               tag = "R5 first read address";
        else if (v.twox && v.bsx > 5'd18)             tag = "R11 first read address";
        else if (v.twox)                              tag = "R3 first read address";
        else                                          tag = "R2 first read address";
        chk(rd_cnt == e_cnt, "R9 read count", 64'(rd_cnt), 64'(e_cnt));
        chk(rd_addr[0] == e_a0, tag, 64'(rd_addr[0]), 64'(e_a0));
        if (e_cnt == 2)
            chk(rd_addr[1] == e_a1, "R4 table read address", 64'(rd_addr[1]), 64'(e_a1));
        chk(res_fault == e_fault, e_tbl ? "R7 fault flag" : "R6 fault flag", 64'(res_fault), 64'(e_fault));
        if (e_fault)
            chk(res_fault_tbl == e_tbl, "R6 R7 fault source", 64'(res_fault_tbl), 64'(e_tbl));
        else
            check_fields(e_pte);
        chk(!req_ready, "R10 busy during result", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk(!res_valid && req_ready, "R10 single pulse", 64'({res_valid, req_ready}), 64'b01);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic got;
        for (int c = 0; c < NCTX; c++) ctx_base[c] = base_of(c);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !mem_req_valid && !res_valid, "R1 reset state",
            64'({req_ready, mem_req_valid, res_valid}), 64'b100);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !res_valid, "R1 idle after reset",
            64'({req_ready, mem_req_valid, res_valid}), 64'b100);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R10 and R5: second request held valid through the first walk
        @(negedge clk);
        cfg0_two_level = 1'b0; cfgx_two_level = 1'b0; stall_mode = 1'b0;
        mem_w0 = 64'h0000_0011_1111_1063; mem_w1 = 64'h0000_0022_2222_2045;
        req_ctx = 4'd4; req_va = 40'h00_0000_5000; req_valid = 1'b1; rec_clr = 1'b1;
        @(negedge clk);
        rec_clr = 1'b0;
        req_ctx = 4'd6; req_va = 40'h00_0000_8000;
        wait_result(got);
        chk(got && !req_ready, "R10 request held off during result", 64'(req_ready), 64'd0);
        chk(res_page == mem_w0[39:12], "R10 first result intact", 64'(res_page), 64'(mem_w0[39:12]));
        @(negedge clk);
        chk(req_ready, "R10 idle after pulse", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_result(got);
        chk(got && res_page == mem_w1[39:12], "R10 second result", 64'(res_page), 64'(mem_w1[39:12]));
        chk(rd_addr[1] == 40'(base_of(6) + (40'h8 << 3)), "R5 second context base",
            64'(rd_addr[1]), 64'(base_of(6) + (40'h8 << 3)));

        // R1: reset during a stalled walk returns to idle
        @(negedge clk);
        stall_mode = 1'b1; cfgx_two_level = 1'b1;
        req_ctx = 4'd8; req_va = 40'h00_0010_0000; req_valid = 1'b1; rec_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rec_clr = 1'b0;
        chk(!req_ready, "R10 busy while walking", 64'(req_ready), 64'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !res_valid, "R1 reset mid-walk",
            64'({req_ready, mem_req_valid, res_valid}), 64'b100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!res_valid && !mem_req_valid, "R9 stray response ignored",
            64'({res_valid, mem_req_valid}), 64'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule